// File: doc/BRIEF.md
# Board Control and Status Register File

This block is a small memory-mapped register file sitting on a plain 32-bit read/write bus. It holds the state that a board controller exposes to software:
- an eight-segment LED bar value;
- an eight-character ASCII display buffer;
- a break code register;
- a general-purpose output byte;
- a set of registers that bit-bang a two-wire serial EEPROM port.

It also answers a few fixed read-only locations: switches, status and jumpers. The bus decodes only the low 20 address bits, so the block can sit in any aligned window.

Two writes do more than store a value. A write to the hex-word location turns the 32-bit write data into eight upper-case hexadecimal ASCII characters and loads the whole display at once. A write to the soft-reset location raises a one-cycle system reset request, but only when the data equals the magic value 0x42.

Reads have one cycle of latency: `bus_rdata` is loaded on the clock edge that samples `bus_rd`, and it holds until the next read. Writes take effect on the edge that samples `bus_wr`.

The block has no state machine. All behaviour is decode plus registers.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, the following hold:
  - `led_bar`, `gp_out` and `i2c_oe` are 0.
  - `brk_code` is 0x0A.
  - `i2c_scl_o` and `i2c_sda_o` are 1, and offset 0xB10 reads 0x3.
  - `i2c_sel` is 1.
  - All eight display characters are ASCII space (0x20).
  - `sys_reset_req` is 0.
- R2: A write to offset 0x408 stores bits [7:0] of the data on `led_bar`. A read of 0x408 returns that byte zero-extended.
- R3: A write to offset 0x410 loads display character k (`disp_text[8k+7:8k]`, k = 0..7) with the upper-case ASCII hex digit ('0'-'9' = 0x30-0x39, 'A'-'F' = 0x41-0x46) of data nibble [31-4k:28-4k]. Character 0 therefore holds the most significant nibble.
- R4: A write to offset 0x418 + 8k (k = 0..7) stores data bits [7:0] in display character k only. Offsets between these slots, such as 0x41C, change nothing.
- R5: A write of exactly 0x00000042 to offset 0x500 raises `sys_reset_req` for exactly one cycle after the write edge. Any other data, including 0x142, raises nothing.
- R6: Offset 0x508 (`brk_code`) and offset 0xA00 (`gp_out`) each keep bits [7:0] of a write and read back zero-extended.
- R7: Offset 0xB08 keeps data bits [1:0] as `i2c_oe`. Offset 0xB18 keeps data bit 0 as `i2c_sel`. Both read back zero-extended.
- R8: A write to offset 0xB10 stores the full 32-bit word and drives `i2c_scl_o` from bit 1 and `i2c_sda_o` from bit 0. A read of 0xB10 returns the stored word.
- R9: A read of offset 0xB00 returns 0x2 with `eeprom_sda_i` in bit 0: 0x2 when the input is 0, and 0x3 when it is 1.
- R10: A read of offset 0xA08 returns the word stored at 0xB10 when `i2c_sel` is 1, and returns 0 when it is 0.
- R11: Offsets 0x200 and 0x210 read as 0. Offset 0x208 reads 0x10 with `BIG_ENDIAN` = 0 and 0x12 with `BIG_ENDIAN` = 1.
- R12: Only address bits [19:0] are decoded, so 0xABC00408 reaches the LED register. Unmapped offsets read 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address; low 20 bits decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, loaded one edge after `bus_rd` |
| eeprom_sda_i | input | 1 | Data line returned by the serial EEPROM |
| led_bar | output | 8 | LED bar value |
| disp_text | output | 8*DATA_W/4 | Display characters, character k in bits [8k+7:8k] |
| brk_code | output | 8 | Break code register |
| gp_out | output | 8 | General-purpose output byte |
| i2c_oe | output | 2 | EEPROM port output enables |
| i2c_scl_o | output | 1 | Clock line toward the EEPROM |
| i2c_sda_o | output | 1 | Data line toward the EEPROM |
| i2c_sel | output | 1 | Select bit gating the 0xA08 readback |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench aims at the magic-value comparison:
- It writes 0x43 and 0x142 to the soft-reset location. A design that compared only the low byte would pulse on 0x142.
- A design that held the request for more than one cycle would be caught by the one-cycle check.

The hex conversion is driven with words that cover the 9/A nibble boundary and all of 0-F. An off-by-one in the letter offset, or a reversed nibble order, would show up as wrong characters.

The bench writes the last character slot and the misaligned offset 0x41C. A decoder that shifted without checking alignment would corrupt a neighbouring character.

The bench also reads 0xA08 with the select bit cleared and accesses an aliased high address. This catches readback gating that ignores the select bit and decode that uses the full address.

// File: rtl/board_ctl_pkg.sv
`timescale 1ns/1ps
package board_ctl_pkg;

    localparam int OFFS_W = 20;

    localparam logic [OFFS_W-1:0] OFF_SWITCH  = 20'h00200;
    localparam logic [OFFS_W-1:0] OFF_STATUS  = 20'h00208;
    localparam logic [OFFS_W-1:0] OFF_JUMPER  = 20'h00210;
    localparam logic [OFFS_W-1:0] OFF_LEDS    = 20'h00408;
    localparam logic [OFFS_W-1:0] OFF_HEXWORD = 20'h00410;
    localparam logic [OFFS_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [OFFS_W-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [OFFS_W-1:0] OFF_BRK     = 20'h00508;
    localparam logic [OFFS_W-1:0] OFF_GPO     = 20'h00A00;
    localparam logic [OFFS_W-1:0] OFF_GPI     = 20'h00A08;
    localparam logic [OFFS_W-1:0] OFF_I2C_IN  = 20'h00B00;
    localparam logic [OFFS_W-1:0] OFF_I2C_OE  = 20'h00B08;
    localparam logic [OFFS_W-1:0] OFF_I2C_OUT = 20'h00B10;
    localparam logic [OFFS_W-1:0] OFF_I2C_SEL = 20'h00B18;

    localparam int          CHAR_STRIDE = 8;
    localparam logic [7:0]  RESET_MAGIC = 8'h42;
    localparam logic [7:0]  ASCII_SPACE = 8'h20;
    localparam logic [7:0]  BRK_RST     = 8'h0A;
    localparam logic [1:0]  I2C_OUT_RST = 2'b11;
    localparam logic [1:0]  I2C_IN_RST  = 2'b11;

    // Map one nibble to its upper-case hexadecimal ASCII digit
    function automatic logic [7:0] nib2ascii(input logic [3:0] n);
        if (n < 4'd10)
            return 8'h30 + {4'h0, n};
        else
            return 8'h37 + {4'h0, n};
    endfunction

endpackage

// File: rtl/board_ctl_hexfmt.sv
`timescale 1ns/1ps
module board_ctl_hexfmt
    import board_ctl_pkg::*;
#(
    parameter int NCHARS = 8
) (
    input  logic [4*NCHARS-1:0] word,
    output logic [8*NCHARS-1:0] chars
);

    // Character 0 takes the most significant nibble
    for (genvar i = 0; i < NCHARS; i++) begin : g_digit
        assign chars[8*i +: 8] = nib2ascii(word[4*(NCHARS-1-i) +: 4]);
    end

endmodule

// File: rtl/board_ctl_dispbuf.sv
`timescale 1ns/1ps
module board_ctl_dispbuf
    import board_ctl_pkg::*;
#(
    parameter int NCHARS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_all,
    input  logic [8*NCHARS-1:0] all_chars,
    input  logic [NCHARS-1:0]   char_we,
    input  logic [7:0]          char_data,
    output logic [8*NCHARS-1:0] text
);

    for (genvar i = 0; i < NCHARS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                text[8*i +: 8] <= ASCII_SPACE;
            else if (load_all)
                text[8*i +: 8] <= all_chars[8*i +: 8];
            else if (char_we[i])
                text[8*i +: 8] <= char_data;
        end
    end

endmodule

// File: rtl/board_ctl_rdmux.sv
`timescale 1ns/1ps
module board_ctl_rdmux
    import board_ctl_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [OFFS_W-1:0] offset,
    input  logic [7:0]        led_q,
    input  logic [7:0]        brk_q,
    input  logic [7:0]        gpo_q,
    input  logic [1:0]        oe_q,
    input  logic [DATA_W-1:0] i2c_out_q,
    input  logic              sel_q,
    input  logic              sda_in,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? DATA_W'(8'h12) : DATA_W'(8'h10);
    localparam logic [DATA_W-1:0] IN_RST     = DATA_W'(I2C_IN_RST);

    always_comb begin
        rdata = '0;
        case (offset)
            OFF_SWITCH:  rdata = '0;
            OFF_STATUS:  rdata = STATUS_VAL;
            OFF_JUMPER:  rdata = '0;
            OFF_LEDS:    rdata = DATA_W'(led_q);
            OFF_BRK:     rdata = DATA_W'(brk_q);
            OFF_GPO:     rdata = DATA_W'(gpo_q);
            OFF_GPI:     rdata = sel_q ? i2c_out_q : '0;
            OFF_I2C_IN:  rdata = {IN_RST[DATA_W-1:1], sda_in};
            OFF_I2C_OE:  rdata = DATA_W'(oe_q);
            OFF_I2C_OUT: rdata = i2c_out_q;
            OFF_I2C_SEL: rdata = DATA_W'(sel_q);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/board_ctl_regs.sv
`timescale 1ns/1ps
module board_ctl_regs
    import board_ctl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     eeprom_sda_i,
    output logic [7:0]               led_bar,
    output logic [8*(DATA_W/4)-1:0]  disp_text,
    output logic [7:0]               brk_code,
    output logic [7:0]               gp_out,
    output logic [1:0]               i2c_oe,
    output logic                     i2c_scl_o,
    output logic                     i2c_sda_o,
    output logic                     i2c_sel,
    output logic                     sys_reset_req
);

    localparam int NCHARS = DATA_W / 4;

    logic [OFFS_W-1:0]   offset;
    logic                unused_addr_hi;
    logic [DATA_W-1:0]   i2c_out_q;
    logic [8*NCHARS-1:0] hex_chars;
    logic [NCHARS-1:0]   char_we;
    logic [DATA_W-1:0]   rdata_next;
    logic                hex_load;

    assign offset         = bus_addr[OFFS_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFFS_W];
    assign hex_load       = bus_wr && (offset == OFF_HEXWORD);

    // Per-slot write enables for single-character writes
    for (genvar i = 0; i < NCHARS; i++) begin : g_char_we
        assign char_we[i] = bus_wr && (offset == OFF_CHAR0 + OFFS_W'(i * CHAR_STRIDE));
    end

    board_ctl_hexfmt #(.NCHARS(NCHARS)) u_hexfmt (
        .word  (bus_wdata),
        .chars (hex_chars)
    );

    board_ctl_dispbuf #(.NCHARS(NCHARS)) u_dispbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_all  (hex_load),
        .all_chars (hex_chars),
        .char_we   (char_we),
        .char_data (bus_wdata[7:0]),
        .text      (disp_text)
    );

    board_ctl_rdmux #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_rdmux (
        .offset    (offset),
        .led_q     (led_bar),
        .brk_q     (brk_code),
        .gpo_q     (gp_out),
        .oe_q      (i2c_oe),
        .i2c_out_q (i2c_out_q),
        .sel_q     (i2c_sel),
        .sda_in    (eeprom_sda_i),
        .rdata     (rdata_next)
    );

    // Writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_bar   <= '0;
            brk_code  <= BRK_RST;
            gp_out    <= '0;
            i2c_oe    <= '0;
            i2c_out_q <= DATA_W'(I2C_OUT_RST);
            i2c_sel   <= 1'b1;
        end else if (bus_wr) begin
            case (offset)
                OFF_LEDS:    led_bar   <= bus_wdata[7:0];
                OFF_BRK:     brk_code  <= bus_wdata[7:0];
                OFF_GPO:     gp_out    <= bus_wdata[7:0];
                OFF_I2C_OE:  i2c_oe    <= bus_wdata[1:0];
                OFF_I2C_OUT: i2c_out_q <= bus_wdata;
                OFF_I2C_SEL: i2c_sel   <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    assign i2c_scl_o = i2c_out_q[1];
    assign i2c_sda_o = i2c_out_q[0];

    // One-cycle reset request on exact magic word
    always_ff @(posedge clk) begin
        if (!rst_n)
            sys_reset_req <= 1'b0;
        else
            sys_reset_req <= bus_wr && (offset == OFF_SOFTRST)
                             && (bus_wdata == DATA_W'(RESET_MAGIC));
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rdata_next;
    end

endmodule

// File: rtl/board_ctl_regs_chk.sv
`timescale 1ns/1ps
module board_ctl_regs_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [7:0]        led_bar,
    input logic [1:0]        i2c_oe,
    input logic              i2c_scl_o,
    input logic              i2c_sda_o,
    input logic              sys_reset_req
);

    logic [19:0] off;
    assign off = bus_addr[19:0];

    // R5: the request never lasts two cycles
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    // R5: a request only follows a magic write to the soft-reset offset
    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_wr && off == 20'h00500 && bus_wdata == 32'h42));

    // R2: the LED bar only moves after a write to its offset
    a_r2_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && off == 20'h00408) |=> $stable(led_bar));

    // R7: output enables only move after a write to their offset
    a_r7_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && off == 20'h00B08) |=> $stable(i2c_oe));

    // R8: the EEPROM pins follow the bits of the write
    a_r8_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == 20'h00B10) |=>
            (i2c_scl_o == $past(bus_wdata[1]) && i2c_sda_o == $past(bus_wdata[0])));

endmodule

bind board_ctl_regs board_ctl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .led_bar       (led_bar),
    .i2c_oe        (i2c_oe),
    .i2c_scl_o     (i2c_scl_o),
    .i2c_sda_o     (i2c_sda_o),
    .sys_reset_req (sys_reset_req)
);

// File: tb/board_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module board_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eeprom_sda_i = 1'b0;
    logic [7:0]  led_bar;
    logic [63:0] disp_text;
    logic [7:0]  brk_code;
    logic [7:0]  gp_out;
    logic [1:0]  i2c_oe;
    logic        i2c_scl_o;
    logic        i2c_sda_o;
    logic        i2c_sel;
    logic        sys_reset_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    board_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eeprom_sda_i(eeprom_sda_i), .led_bar(led_bar), .disp_text(disp_text),
        .brk_code(brk_code), .gp_out(gp_out), .i2c_oe(i2c_oe),
        .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o), .i2c_sel(i2c_sel),
        .sys_reset_req(sys_reset_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = '0;
        d = bus_rdata;
    endtask

    function automatic logic [63:0] hex_text(input logic [31:0] w);
        string digits = "0123456789ABCDEF";
        logic [63:0] t;
        for (int k = 0; k < 8; k++)
            t[8*k +: 8] = digits[w[31-4*k -: 4]];
        return t;
    endfunction

    task automatic t_reset_state();
        logic [31:0] d;
        check("R1 led_bar", led_bar, 0);
        check("R1 brk_code", brk_code, 8'h0A);
        check("R1 gp_out", gp_out, 0);
        check("R1 i2c_oe", i2c_oe, 0);
        check("R1 scl/sda", {i2c_scl_o, i2c_sda_o}, 2'b11);
        check("R1 i2c_sel", i2c_sel, 1);
        check("R1 display", disp_text, 64'h2020202020202020);
        check("R1 reset req", sys_reset_req, 0);
        rd(32'h508, d); check("R1 read brk", d, 32'h0A);
        rd(32'hB10, d); check("R1 read i2c out", d, 32'h3);
    endtask

    task automatic t_leds();
        logic [31:0] d;
        wr(32'h408, 32'h1234_51A5);
        check("R2 led_bar", led_bar, 8'hA5);
        rd(32'h408, d); check("R2 read led", d, 32'hA5);
    endtask

    task automatic t_hexword();
        wr(32'h410, 32'hDEAD_BEEF);
        check("R3 hex DEADBEEF", disp_text, hex_text(32'hDEAD_BEEF));
        wr(32'h410, 32'h9A01_2345);
        check("R3 hex 9A012345", disp_text, hex_text(32'h9A01_2345));
        wr(32'h410, 32'h6789_BCDF);
        check("R3 hex 6789BCDF", disp_text, hex_text(32'h6789_BCDF));
        check("R3 char0 is MS nibble", disp_text[7:0], 8'h36);
    endtask

    task automatic t_chars();
        logic [63:0] exp;
        exp = disp_text;
        wr(32'h418, 32'hFFFF_FF41); exp[7:0] = 8'h41;
        check("R4 slot0", disp_text, exp);
        wr(32'h450, 32'h0000_017A); exp[63:56] = 8'h7A;
        check("R4 slot7", disp_text, exp);
        wr(32'h430, 32'h0000_0055); exp[31:24] = 8'h55;
        check("R4 slot3", disp_text, exp);
        wr(32'h41C, 32'h0000_0099);
        check("R4 misaligned 0x41C ignored", disp_text, exp);
    endtask

    task automatic t_softreset();
        wr(32'h500, 32'h43);
        check("R5 no pulse on 0x43", sys_reset_req, 0);
        wr(32'h500, 32'h142);
        check("R5 no pulse on 0x142", sys_reset_req, 0);
        wr(32'h504, 32'h42);
        check("R5 no pulse at 0x504", sys_reset_req, 0);
        wr(32'h500, 32'h42);
        check("R5 pulse on 0x42", sys_reset_req, 1);
        @(negedge clk);
        check("R5 pulse one cycle", sys_reset_req, 0);
    endtask

    task automatic t_brk_gpo();
        logic [31:0] d;
        wr(32'h508, 32'hFFFF_FF3C);
        check("R6 brk_code", brk_code, 8'h3C);
        rd(32'h508, d); check("R6 read brk", d, 32'h3C);
        wr(32'hA00, 32'h0000_01C3);
        check("R6 gp_out", gp_out, 8'hC3);
        rd(32'hA00, d); check("R6 read gpo", d, 32'hC3);
    endtask

    task automatic t_i2c();
        logic [31:0] d;
        wr(32'hB08, 32'hFFFF_FFFE);
        check("R7 i2c_oe", i2c_oe, 2'b10);
        rd(32'hB08, d); check("R7 read oe", d, 32'h2);
        wr(32'hB10, 32'hCAFE_0002);
        check("R8 scl=1 sda=0", {i2c_scl_o, i2c_sda_o}, 2'b10);
        rd(32'hB10, d); check("R8 read i2c out", d, 32'hCAFE_0002);
        wr(32'hB10, 32'h0000_0001);
        check("R8 scl=0 sda=1", {i2c_scl_o, i2c_sda_o}, 2'b01);
        eeprom_sda_i = 1'b0;
        rd(32'hB00, d); check("R9 sda in 0", d, 32'h2);
        eeprom_sda_i = 1'b1;
        rd(32'hB00, d); check("R9 sda in 1", d, 32'h3);
        rd(32'hA08, d); check("R10 sel=1 readback", d, 32'h1);
        wr(32'hB18, 32'hFFFF_FFFE);
        check("R7 i2c_sel cleared", i2c_sel, 0);
        rd(32'hB18, d); check("R7 read sel", d, 32'h0);
        rd(32'hA08, d); check("R10 sel=0 reads 0", d, 32'h0);
        wr(32'hB18, 32'h1);
        rd(32'hA08, d); check("R10 sel restored", d, 32'h1);
    endtask

    task automatic t_fixed_and_decode();
        logic [31:0] d;
        logic [63:0] txt;
        rd(32'h200, d); check("R11 switch", d, 0);
        rd(32'h210, d); check("R11 jumper", d, 0);
        rd(32'h208, d); check("R11 status LE", d, 32'h10);
        wr(32'hABC0_0408, 32'h5E);
        check("R12 aliased led write", led_bar, 8'h5E);
        rd(32'h7770_0408, d); check("R12 aliased led read", d, 32'h5E);
        txt = disp_text;
        wr(32'h404, 32'hFF);
        wr(32'hC00, 32'hFF);
        check("R12 unmapped write led", led_bar, 8'h5E);
        check("R12 unmapped write gpo", gp_out, 8'hC3);
        check("R12 unmapped write disp", disp_text, txt);
        rd(32'h404, d); check("R12 unmapped read", d, 0);
        rd(32'h410, d); check("R12 hex word reads 0", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_leds();
        t_hexword();
        t_chars();
        t_softreset();
        t_brk_gpo();
        t_i2c();
        t_fixed_and_decode();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule